// File: doc/BRIEF.md
# Single-Line Interrupt Controller

This block watches one asynchronous interrupt pin and turns it into a clean, level-type interrupt request for a processor. A two-bit trigger setting picks one of four conditions to watch for: the pin held low, the pin held high, a falling transition or a rising transition. When the chosen condition is seen, a sticky pending flag is set. The request output is asserted while that flag is set and the source is unmasked.

Software reaches three registers over a small 32-bit bus with separate read and write strobes. It uses them to choose the trigger condition, to mask or unmask the source, and to read the pending flag. Writing a one to bit 0 of the pending register clears the flag. A pending read of zero tells the interrupt handler that the request was spurious. The register addresses come from a layout parameter, so one netlist serves several address maps. There is exactly one source, number 0.

Top module: `irq_line_ctrl`

## Requirements
- R1: After reset the trigger setting, the enable bit and the pending flag all read zero, and `irq_out` is low.
- R2: Trigger code 0 (bits [1:0] of the control register) sets pending on every cycle in which the synchronized pin is low. While the pin stays high, pending does not set.
- R3: Trigger code 1 sets pending only when the synchronized pin goes from high to low. A pin that stays low, or a rising transition, leaves pending clear.
- R4: Trigger code 2 sets pending on every cycle in which the synchronized pin is high. While the pin stays low, pending does not set.
- R5: Trigger code 3 sets pending only when the synchronized pin goes from low to high. A pin that stays high leaves pending clear.
- R6: A write to the pending register with bit 0 set clears the flag. A write with bit 0 clear has no effect on it.
- R7: In a level mode, an acknowledge made while the pin is still active leaves pending set.
- R8: When a trigger event and an acknowledge write occur in the same cycle, pending stays set.
- R9: `irq_out` is a registered copy of (pending AND enable bit 0). It updates one cycle after either of them changes. Pending still latches while the source is masked, and a write with bit 0 clear masks the source.
- R10: While `bus_rd` is high, `bus_rdata` returns the addressed register: trigger code in [1:0], pending in bit 0, enable in bit 0, with all other bits zero. An unmapped address reads zero. While `bus_rd` is low, `bus_rdata` is zero.
- R11: The register offsets depend on `LAYOUT`:
  - 0: control 0x00, pending 0x04, enable 0x08.
  - 1: control 0x00, pending 0x04, enable 0x34.
  - 2: control 0x0C, pending 0x10, enable 0x40.
- R12: With the default two synchronizer stages, a change on `irq_in` made before clock edge 1 sets pending at edge 3, not earlier. A source in a level mode that is already unmasked then raises `irq_out` at edge 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational while bus_rd is high |
| irq_in | input | 1 | Asynchronous interrupt pin |
| irq_out | output | 1 | Registered interrupt request |

## Verification
The two functions that can meet in one cycle are the detection of a new trigger event and the software acknowledge of the pending flag. The bench provokes this in rising-edge mode. It makes the pin toggle while pending is already set, then times the acknowledge strobe to land exactly on the clock edge where the transition leaves the synchronizer, two edges after the pin change. A read of pending that still returns one is the pass condition. A plain acknowledge with no event beside it, which must clear the flag, is checked next to it as the contrast case. The level-mode acknowledge with the pin still active is the second form of the same collision.

// File: rtl/irq_line_pkg.sv
package irq_line_pkg;

  // Trigger condition selected by control bits [1:0]
  typedef enum logic [1:0] {
    TRIG_LEVEL_LOW  = 2'd0,
    TRIG_EDGE_FALL  = 2'd1,
    TRIG_LEVEL_HIGH = 2'd2,
    TRIG_EDGE_RISE  = 2'd3
  } trig_mode_e;

  typedef struct packed {
    int unsigned ctrl;
    int unsigned pend;
    int unsigned en;
  } reg_map_t;

  // Address layout chosen by the LAYOUT parameter (R11)
  function automatic reg_map_t layout_map(input int unsigned layout);
    reg_map_t m;
    case (layout)
      1:       m = '{ctrl: 32'h00, pend: 32'h04, en: 32'h34};
      2:       m = '{ctrl: 32'h0C, pend: 32'h10, en: 32'h40};
      default: m = '{ctrl: 32'h00, pend: 32'h04, en: 32'h08};
    endcase
    return m;
  endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    logic nxt;
    logic q_r;
    if (i == 0) begin : g_first
      assign nxt = d;
    end else begin : g_next
      assign nxt = g_stage[i-1].q_r;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_r <= RST_VAL;
      else        q_r <= nxt;
    end
  end

  assign q = g_stage[STAGES-1].q_r;

endmodule

// File: rtl/irq_trig_detect.sv
module irq_trig_detect
  import irq_line_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lvl,
  input  trig_mode_e mode,
  output logic       evt
);

  logic prev_q;

  // Previous synchronized sample, idle-high after reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= lvl;
  end

  always_comb begin
    evt = 1'b0;
    unique case (mode)
      TRIG_LEVEL_LOW:  evt = ~lvl;
      TRIG_EDGE_FALL:  evt = prev_q & ~lvl;
      TRIG_LEVEL_HIGH: evt = lvl;
      TRIG_EDGE_RISE:  evt = ~prev_q & lvl;
      default:         evt = 1'b0;
    endcase
  end

endmodule

// File: rtl/irq_regfile.sv
module irq_regfile
  import irq_line_pkg::*;
#(
  parameter int          ADDR_W   = 8,
  parameter int          DATA_W   = 32,
  parameter int unsigned CTRL_OFS = 0,
  parameter int unsigned PEND_OFS = 4,
  parameter int unsigned EN_OFS   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              evt,
  output trig_mode_e        mode,
  output logic              en_q,
  output logic              pend_q,
  output logic              ack
);

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_OFS);
  localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(PEND_OFS);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(EN_OFS);

  logic sel_ctrl, sel_pend, sel_en;
  logic unused_wdata;

  assign sel_ctrl     = (addr == A_CTRL);
  assign sel_pend     = (addr == A_PEND);
  assign sel_en       = (addr == A_EN);
  assign ack          = wr_en & sel_pend & wdata[0];
  assign unused_wdata = ^wdata[DATA_W-1:2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= TRIG_LEVEL_LOW;
      en_q <= 1'b0;
    end else if (wr_en) begin
      if (sel_ctrl) mode <= trig_mode_e'(wdata[1:0]);
      if (sel_en)   en_q <= wdata[0];
    end
  end

  // New event wins over a same-cycle acknowledge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= evt | (pend_q & ~ack);
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      if (sel_ctrl)      rdata[1:0] = mode;
      else if (sel_pend) rdata[0]   = pend_q;
      else if (sel_en)   rdata[0]   = en_q;
    end
  end

endmodule

// File: rtl/irq_line_ctrl.sv
module irq_line_ctrl
  import irq_line_pkg::*;
#(
  parameter int unsigned LAYOUT      = 0,
  parameter int          ADDR_W      = 8,
  parameter int          DATA_W      = 32,
  parameter int          SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              irq_in,
  output logic              irq_out
);

  localparam reg_map_t    MAP      = layout_map(LAYOUT);
  localparam int unsigned CTRL_OFS = MAP.ctrl;
  localparam int unsigned PEND_OFS = MAP.pend;
  localparam int unsigned EN_OFS   = MAP.en;

  logic       line_sync;
  logic       trig_evt;
  trig_mode_e mode;
  logic       en_q;
  logic       pend_q;
  logic       ack_hit;

  irq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (irq_in),
    .q     (line_sync)
  );

  irq_trig_detect u_detect (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl   (line_sync),
    .mode  (mode),
    .evt   (trig_evt)
  );

  irq_regfile #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .CTRL_OFS (CTRL_OFS),
    .PEND_OFS (PEND_OFS),
    .EN_OFS   (EN_OFS)
  ) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (bus_wr),
    .rd_en  (bus_rd),
    .addr   (bus_addr),
    .wdata  (bus_wdata),
    .rdata  (bus_rdata),
    .evt    (trig_evt),
    .mode   (mode),
    .en_q   (en_q),
    .pend_q (pend_q),
    .ack    (ack_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_out <= 1'b0;
    else        irq_out <= pend_q & en_q;
  end

endmodule

// File: rtl/irq_line_ctrl_chk.sv
module irq_line_ctrl_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_rd,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              irq_out,
  input logic              pend,
  input logic              en,
  input logic              evt,
  input logic              ack
);

  AST_OUT_RISES: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && en) |=> irq_out); // R9
  AST_OUT_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
    !(pend && en) |=> !irq_out); // R9
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !evt) |=> !pend); // R6
  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !ack) |=> pend); // R6
  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> pend); // R8
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend && !evt) |=> !pend); // R3
  AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> (bus_rdata == '0)); // R10

endmodule

bind irq_line_ctrl irq_line_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_rd    (bus_rd),
  .bus_rdata (bus_rdata),
  .irq_out   (irq_out),
  .pend      (pend_q),
  .en        (en_q),
  .evt       (trig_evt),
  .ack       (ack_hit)
);

// File: tb/tb_irq_line_ctrl.sv
module tb_irq_line_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic        rd = 1'b0;
  logic        pin = 1'b1;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata0, rdata1, rdata2;
  logic        irq0, irq1, irq2;
  logic [31:0] r0, r1, r2;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  finished = 1'b0;

  always #10 clk = ~clk;

  irq_line_ctrl #(.LAYOUT(0)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(wr), .bus_rd(rd), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata0), .irq_in(pin), .irq_out(irq0));
  irq_line_ctrl #(.LAYOUT(1)) dut_l1 (
    .clk(clk), .rst_n(rst_n), .bus_wr(wr), .bus_rd(rd), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata1), .irq_in(pin), .irq_out(irq1));
  irq_line_ctrl #(.LAYOUT(2)) dut_l2 (
    .clk(clk), .rst_n(rst_n), .bus_wr(wr), .bus_rd(rd), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata2), .irq_in(pin), .irq_out(irq2));

  task automatic check_eq(input string req, input string what,
                          input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // All bus tasks start and end at a falling edge
  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0; wdata = '0;
  endtask

  task automatic rd_reg(input logic [7:0] a);
    rd = 1'b1; addr = a;
    #5;
    r0 = rdata0; r1 = rdata1; r2 = rdata2;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    rd_reg(8'h00); check_eq("R1", "control after reset", r0, 0);
    rd_reg(8'h04); check_eq("R1", "pending after reset", r0, 0);
    rd_reg(8'h08); check_eq("R1", "enable after reset", r0, 0);
    check_eq("R1", "irq_out after reset", {31'b0, irq0}, 0);
  endtask

  task automatic t_level_low;
    wr_reg(8'h08, 1);
    idle(2);
    rd_reg(8'h04); check_eq("R2", "pending with pin high", r0, 0);
    pin = 1'b0;
    idle(2);
    rd_reg(8'h04); check_eq("R12", "pending before edge 3", r0, 0);
    rd_reg(8'h04); check_eq("R2", "pending at edge 3 (R12)", r0, 1);
    check_eq("R12", "irq_out at edge 4", {31'b0, irq0}, 1);
    pin = 1'b1;
    idle(3);
    wr_reg(8'h04, 1);
    rd_reg(8'h04); check_eq("R6", "pending after ack", r0, 0);
    check_eq("R9", "irq_out drops after ack", {31'b0, irq0}, 0);
  endtask

  task automatic t_edge_fall;
    wr_reg(8'h00, 1);
    idle(3);
    wr_reg(8'h04, 1);
    rd_reg(8'h04); check_eq("R3", "fall mode idle high", r0, 0);
    pin = 1'b0;
    idle(3);
    rd_reg(8'h04); check_eq("R3", "pending after falling edge", r0, 1);
    wr_reg(8'h04, 1);
    idle(3);
    rd_reg(8'h04); check_eq("R3", "steady low does not retrigger", r0, 0);
    pin = 1'b1;
    idle(3);
    rd_reg(8'h04); check_eq("R3", "rising edge ignored", r0, 0);
  endtask

  task automatic t_level_high;
    wr_reg(8'h00, 2);
    idle(3);
    rd_reg(8'h04); check_eq("R4", "pending with pin high", r0, 1);
    wr_reg(8'h04, 1);
    rd_reg(8'h04); check_eq("R7", "ack while active keeps pending", r0, 1);
    pin = 1'b0;
    idle(3);
    wr_reg(8'h04, 1);
    rd_reg(8'h04); check_eq("R4", "ack after line inactive", r0, 0);
    idle(3);
    rd_reg(8'h04); check_eq("R4", "low pin leaves pending clear", r0, 0);
  endtask

  task automatic t_edge_rise;
    wr_reg(8'h00, 3);
    idle(2);
    rd_reg(8'h04); check_eq("R5", "rise mode idle low", r0, 0);
    pin = 1'b1;
    idle(3);
    rd_reg(8'h04); check_eq("R5", "pending after rising edge", r0, 1);
    wr_reg(8'h04, 0);
    rd_reg(8'h04); check_eq("R6", "write of zero keeps pending", r0, 1);
    wr_reg(8'h04, 1);
    idle(3);
    rd_reg(8'h04); check_eq("R5", "steady high does not retrigger", r0, 0);
  endtask

  task automatic t_coincide;
    pin = 1'b0; idle(3);
    pin = 1'b1; idle(3);
    rd_reg(8'h04); check_eq("R5", "second rising edge", r0, 1);
    pin = 1'b0; idle(3);
    pin = 1'b1; idle(2);
    wr_reg(8'h04, 1);  // strobe lands on the event edge
    rd_reg(8'h04); check_eq("R8", "event and ack same cycle", r0, 1);
    wr_reg(8'h04, 1);
    rd_reg(8'h04); check_eq("R6", "lone ack clears", r0, 0);
  endtask

  task automatic t_mask;
    wr_reg(8'h08, 0);
    pin = 1'b0; idle(3);
    pin = 1'b1; idle(4);
    check_eq("R9", "masked irq_out", {31'b0, irq0}, 0);
    rd_reg(8'h04); check_eq("R9", "pending latched while masked", r0, 1);
    wr_reg(8'h08, 1);
    check_eq("R9", "irq_out one cycle after enable", {31'b0, irq0}, 0);
    idle(1);
    check_eq("R9", "irq_out after unmask", {31'b0, irq0}, 1);
    wr_reg(8'h08, 32'hFFFF_FFFE);
    idle(1);
    check_eq("R9", "irq_out after mask write", {31'b0, irq0}, 0);
    rd_reg(8'h08); check_eq("R9", "enable bit after mask write", r0, 0);
  endtask

  task automatic t_reads;
    rd_reg(8'h00); check_eq("R10", "control readback", r0, 3);
    wr_reg(8'h04, 1);
    rd_reg(8'h04); check_eq("R10", "pending reads zero when clear", r0, 0);
    rd_reg(8'h20); check_eq("R10", "unmapped address", r0, 0);
    addr = 8'h00; rd = 1'b0;
    #5;
    check_eq("R10", "rdata with read strobe low", rdata0, 0);
    @(negedge clk);
  endtask

  task automatic t_layout;
    wr_reg(8'h0C, 2);
    rd_reg(8'h0C);
    check_eq("R11", "layout 2 control at 0x0C", r2, 2);
    check_eq("R11", "layout 0 has nothing at 0x0C", r0, 0);
    wr_reg(8'h40, 1);
    rd_reg(8'h40); check_eq("R11", "layout 2 enable at 0x40", r2, 1);
    idle(3);
    rd_reg(8'h10); check_eq("R11", "layout 2 pending at 0x10", r2, 1);
    check_eq("R11", "layout 2 irq_out", {31'b0, irq2}, 1);
    wr_reg(8'h34, 1);
    rd_reg(8'h34);
    check_eq("R11", "layout 1 enable at 0x34", r1, 1);
    check_eq("R11", "layout 0 has nothing at 0x34", r0, 0);
    rd_reg(8'h08); check_eq("R11", "layout 1 has nothing at 0x08", r1, 0);
  endtask

  initial begin
    idle(4);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_level_low();
    t_edge_fall();
    t_level_high();
    t_edge_rise();
    t_coincide();
    t_mask();
    t_reads();
    t_layout();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule